// File: doc/BRIEF.md
# PWM Duty Capture with Command Watchdog

This block sits between a controller under test and a digital motor plant model. It watches the controller's PWM drive line together with an H-bridge direction bit. From these it produces a signed duty fraction in Q1.15 fixed point, which the plant multiplies by its supply voltage to get the drive voltage. The line is first brought into the clock domain through a two-flop synchronizer. The period and the high time are then counted between consecutive rising edges. Once per PWM period a registered divider turns the pair into a duty value and emits it with a one-cycle strobe.

Reverse drive is carried as a negative duty and is never clamped to zero, so braking and regeneration reach the plant. A programmable watchdog counts clock cycles since the last rising edge. When that count reaches the limit, the block raises a stale-command flag and forces the duty to zero. It does not hold the last command forever. A line stuck high counts as stale in the same way as a line stuck low, since neither produces edges. Very small duties stay valid commands as long as edges keep arriving.

Top module: `pwm_duty_capture`

## Requirements
- R1: After a synchronous active-low reset, `duty_q` is 0, `duty_valid` is 0 and `cmd_stale` is 0.
- R2: For a period of P clock cycles with H cycles high, both measured on the synchronized line from one rising edge to the next, the emitted duty magnitude is floor(H*32768/P) in Q1.15 (bit 15 is the sign, 15 fraction bits).
- R3: When the synchronized direction bit is 1 at the closing rising edge of a period, the emitted duty is the two's-complement negative of the magnitude. Negative values are passed through unclamped.
- R4: `cmd_stale` asserts once more than `wdog_limit` clock cycles pass with no synchronized rising edge. A larger `wdog_limit` keeps it low for longer quiet stretches.
- R5: `cmd_stale` clears in the cycle after the first rising edge following a stale spell. That edge only re-arms the measurement, so the first new duty strobe follows the second edge.
- R6: While `cmd_stale` is high, `duty_q` reads 0 and `duty_valid` stays low.
- R7: A line held constantly high past the limit sets `cmd_stale`, exactly as a line held low does.
- R8: `duty_valid` is a single-cycle strobe issued once per completed period, two cycles after the closing edge is detected. No strobe is issued for the first edge after reset. `duty_q` holds its value between strobes.
- R9: A low-duty command, for example one high cycle per period, yields its small positive value and never raises `cmd_stale` while edges arrive within the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | Asynchronous PWM drive line from the controller |
| dir_rev | input | 1 | Asynchronous H-bridge direction, 1 = reverse |
| wdog_limit | input | WDOG_W | Watchdog limit in clock cycles without a rising edge |
| duty_q | output | 16 | Signed Q1.15 duty fraction |
| duty_valid | output | 1 | One-cycle strobe when a new duty is emitted |
| cmd_stale | output | 1 | Stale-command fault flag |

## Verification
The hardest situation to reach from the ports is recovery from a stale spell. The edge that clears the flag must not produce a strobe built from the long quiet interval, and only the next edge may produce one. The stimulus reaches this by holding the line low, and later high, for longer than the limit. It then resumes pulsing with a fresh pattern and counts strobes after exactly one period. A reference model run every cycle also follows the sign of each period across direction changes. It follows the edges where one PWM pattern gives way to the next, so periods that mix two patterns are checked too.

// File: rtl/pwm_cap_pkg.sv
// Package: shared fixed-point format for the PWM duty capture block.
// Assumes the duty is carried as signed Q1.15 throughout the plant interface.
package pwm_cap_pkg;
    localparam int DUTY_FRAC = 15;
    localparam int DUTY_W    = DUTY_FRAC + 1;
    typedef logic signed [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/pwm_sync_edge.sv
// Module: pwm_sync_edge
// Brings the PWM line and the direction bit into the clock domain with two
// flops each, then detects rising edges of the synchronized PWM level.
// Assumes both inputs are asynchronous and slower than the clock.
module pwm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_i,
    input  logic dir_i,
    output logic lvl_o,
    output logic rise_o,
    output logic dir_o
);
    logic [2:0] pwm_sr;
    logic [1:0] dir_sr;

    // Purpose: shift both inputs through their synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_sr <= '0;
            dir_sr <= '0;
        end else begin
            pwm_sr <= {pwm_sr[1:0], pwm_i};
            dir_sr <= {dir_sr[0], dir_i};
        end
    end

    assign lvl_o  = pwm_sr[1];
    assign rise_o = pwm_sr[1] & ~pwm_sr[2];
    assign dir_o  = dir_sr[1];

    // R8: an edge is never reported two cycles in a row.
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pwm_cmd_watchdog.sv
// Module: pwm_cmd_watchdog
// Counts cycles since the last synchronized rising edge and flags a stale
// command when the count reaches the programmed limit.
// Assumes a limit of zero means the command is always treated as stale.
module pwm_cmd_watchdog #(
    parameter int WDOG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [WDOG_W-1:0] limit_i,
    output logic              stale_o
);
    logic [WDOG_W-1:0] quiet_cnt;

    // Purpose: restart on each edge, else count up and stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (rise_i) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt < limit_i) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign stale_o = (quiet_cnt >= limit_i);

    // R5: an edge clears the fault on the next cycle.
    a_r5_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i && (limit_i != '0) && $stable(limit_i) |=> !stale_o);
    // R4: without an edge and with a fixed limit the fault persists.
    a_r4_stale_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stale_o && !rise_i |=> stale_o || (limit_i != $past(limit_i)));
endmodule

// File: rtl/pwm_period_meter.sv
// Module: pwm_period_meter
// Counts period and high time between consecutive synchronized rising edges
// and registers a measurement at each closing edge. A stale spell disarms it,
// so the edge that ends the spell only restarts counting.
// Assumes counters saturate; a saturated period is discarded.
module pwm_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             rise_i,
    input  logic             dir_i,
    input  logic             stale_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_period_o,
    output logic [CNT_W-1:0] meas_high_o,
    output logic             meas_rev_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] hi_cnt;
    logic             sat_seen;
    logic             armed;

    // Purpose: count the running period and capture it at each closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt       <= '0;
            hi_cnt        <= '0;
            sat_seen      <= 1'b0;
            armed         <= 1'b0;
            meas_valid_o  <= 1'b0;
            meas_period_o <= '0;
            meas_high_o   <= '0;
            meas_rev_o    <= 1'b0;
        end else begin
            meas_valid_o <= 1'b0;
            if (rise_i) begin
                meas_valid_o  <= armed && !sat_seen && !stale_i;
                meas_period_o <= per_cnt;
                meas_high_o   <= hi_cnt;
                meas_rev_o    <= dir_i;
                per_cnt       <= CNT_ONE;
                hi_cnt        <= CNT_ONE;
                sat_seen      <= 1'b0;
                armed         <= 1'b1;
            end else begin
                if (stale_i) begin
                    armed <= 1'b0;
                end
                if (per_cnt == CNT_MAX) begin
                    sat_seen <= 1'b1;
                end else begin
                    per_cnt <= per_cnt + 1'b1;
                    hi_cnt  <= hi_cnt + CNT_W'(lvl_i);
                end
            end
        end
    end

    // R8: a measurement only follows a detected edge.
    a_r8_meas_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> $past(rise_i));
    // R5: the edge closing a stale spell never yields a measurement.
    a_r5_no_meas_from_stale: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i && stale_i |=> !meas_valid_o);
    // R2: high time always stays below the period it belongs to.
    a_r2_high_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> (meas_high_o < meas_period_o));
endmodule

// File: rtl/pwm_duty_scale.sv
// Module: pwm_duty_scale
// Divides high time by period into a Q1.15 magnitude, applies the direction
// sign and registers the result with a one-cycle strobe. Forces zero while
// the command is stale.
// Assumes high time is strictly below the period, so the magnitude fits.
module pwm_duty_scale
    import pwm_cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid_i,
    input  logic [CNT_W-1:0] meas_period_i,
    input  logic [CNT_W-1:0] meas_high_i,
    input  logic             meas_rev_i,
    input  logic             stale_i,
    output duty_t            duty_o,
    output logic             valid_o
);
    localparam int NUM_W = CNT_W + DUTY_FRAC;

    logic [NUM_W-1:0]  num_w;
    logic [NUM_W-1:0]  den_w;
    logic [NUM_W-1:0]  quo_w;
    logic [DUTY_W-1:0] mag_w;
    duty_t             duty_next;

    // Purpose: scale the high/period ratio and attach the sign.
    always_comb begin
        num_w     = {meas_high_i, {DUTY_FRAC{1'b0}}};
        den_w     = {{DUTY_FRAC{1'b0}}, meas_period_i};
        quo_w     = (den_w == '0) ? '0 : (num_w / den_w);
        mag_w     = {1'b0, quo_w[DUTY_FRAC-1:0]};
        duty_next = meas_rev_i ? duty_t'(DUTY_W'(0) - mag_w) : duty_t'(mag_w);
    end

    // Purpose: register a new duty per measurement, or zero on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o  <= '0;
            valid_o <= 1'b0;
        end else if (stale_i) begin
            duty_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= meas_valid_i;
            if (meas_valid_i) begin
                duty_o <= duty_next;
            end
        end
    end

    // R6: a stale command zeroes the duty and suppresses the strobe.
    a_r6_zero_when_stale: assert property (@(posedge clk) disable iff (!rst_n)
        stale_i |=> (duty_o == '0) && !valid_o);
    // R3: forward periods never produce a negative duty.
    a_r3_sign_forward: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_i && !meas_rev_i && !stale_i |=> !duty_o[DUTY_W-1]);
    // R8: duty only changes on a strobe or when forced by a fault.
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid_i && !stale_i |=> $stable(duty_o));
endmodule

// File: rtl/pwm_duty_capture.sv
// Module: pwm_duty_capture (top)
// Turns a PWM drive line and direction bit into a signed Q1.15 duty once per
// period and flags stale commands through a programmable watchdog.
// Assumes PWM periods shorter than 2**CNT_W clock cycles.
module pwm_duty_capture
    import pwm_cap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WDOG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic              dir_rev,
    input  logic [WDOG_W-1:0] wdog_limit,
    output logic [15:0]       duty_q,
    output logic              duty_valid,
    output logic              cmd_stale
);
    logic             lvl_s, rise_s, dir_s, stale_s;
    logic             mv_s, mrev_s;
    logic [CNT_W-1:0] mper_s, mhigh_s;
    duty_t            duty_s;

    pwm_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm_in), .dir_i(dir_rev),
        .lvl_o(lvl_s), .rise_o(rise_s), .dir_o(dir_s)
    );

    pwm_cmd_watchdog #(.WDOG_W(WDOG_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_s), .limit_i(wdog_limit),
        .stale_o(stale_s)
    );

    pwm_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s), .rise_i(rise_s),
        .dir_i(dir_s), .stale_i(stale_s), .meas_valid_o(mv_s),
        .meas_period_o(mper_s), .meas_high_o(mhigh_s), .meas_rev_o(mrev_s)
    );

    pwm_duty_scale #(.CNT_W(CNT_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .meas_valid_i(mv_s), .meas_period_i(mper_s),
        .meas_high_i(mhigh_s), .meas_rev_i(mrev_s), .stale_i(stale_s),
        .duty_o(duty_s), .valid_o(duty_valid)
    );

    assign duty_q    = duty_s;
    assign cmd_stale = stale_s;

    // R1: outputs are quiet in the first cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (duty_q == '0) && !duty_valid && !cmd_stale);
endmodule

// File: tb/tb_pwm_duty_capture.sv
module tb_pwm_duty_capture;
    localparam int CNT_W  = 16;
    localparam int WDOG_W = 24;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwm_in = 1'b0;
    logic              dir_rev = 1'b0;
    logic [WDOG_W-1:0] wdog_limit = WDOG_W'(300);
    logic [15:0]       duty_q;
    logic              duty_valid;
    logic              cmd_stale;

    int checks = 0;
    int errors = 0;

    pwm_duty_capture #(.CNT_W(CNT_W), .WDOG_W(WDOG_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_rev(dir_rev),
        .wdog_limit(wdog_limit), .duty_q(duty_q), .duty_valid(duty_valid),
        .cmd_stale(cmd_stale)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample history queues and integer counters.
    bit pq[$];
    bit dq[$];
    int w_cnt, per, hi, m_per, m_hi;
    bit ovf, armed, m_valid, m_rev;
    int e_duty;
    bit e_valid, e_stale, live;

    always @(posedge clk) begin
        int lim, cur_lvl, cur_rise, cur_dir, stale_b;
        bit nv;
        lim = int'(wdog_limit);
        if (!rst_n) begin
            pq = {1'b0, 1'b0, 1'b0};
            dq = {1'b0, 1'b0};
            w_cnt = 0; per = 0; hi = 0; ovf = 0; armed = 0;
            m_valid = 0; m_per = 0; m_hi = 0; m_rev = 0;
            e_duty = 0; e_valid = 0; e_stale = 0; live = 1;
        end else begin
            cur_lvl  = pq[pq.size()-2];
            cur_rise = pq[pq.size()-2] && !pq[pq.size()-3];
            cur_dir  = dq[dq.size()-2];
            stale_b  = (w_cnt >= lim);
            // output stage uses the measurement registered at the previous edge
            if (stale_b) begin
                e_duty = 0; e_valid = 0;
            end else begin
                e_valid = m_valid;
                if (m_valid) begin
                    e_duty = (m_hi * 32768) / m_per;
                    if (m_rev) e_duty = -e_duty;
                end
            end
            nv = 0;
            if (cur_rise) begin
                nv = armed && !ovf && !stale_b;
                m_per = per; m_hi = hi; m_rev = cur_dir[0];
                per = 1; hi = 1; ovf = 0; armed = 1;
            end else begin
                if (stale_b) armed = 0;
                if (per == CMAX) ovf = 1;
                else begin per++; hi += cur_lvl; end
            end
            m_valid = nv;
            if (cur_rise) w_cnt = 0;
            else if (w_cnt < lim) w_cnt++;
            e_stale = (w_cnt >= lim);
        end
        pq.push_back(pwm_in);
        dq.push_back(dir_rev);
        if (pq.size() > 4) void'(pq.pop_front());
        if (dq.size() > 4) void'(dq.pop_front());
    end

    // Every-cycle comparison plus observation counters for directed checks.
    int   valid_total = 0;
    int   last_duty = 0;
    bit   stale_seen = 0;
    always @(negedge clk) begin
        if (live && rst_n) begin
            check(duty_valid === e_valid, "R8 strobe", int'(duty_valid), int'(e_valid));
            check($signed(duty_q) === e_duty, "R2 R3 R6 duty", int'($signed(duty_q)), e_duty);
            check(cmd_stale === e_stale, "R4 R5 R7 stale", int'(cmd_stale), int'(e_stale));
            if (duty_valid) begin
                valid_total++;
                last_duty = int'($signed(duty_q));
            end
            if (cmd_stale) stale_seen = 1;
        end
    end

    task automatic drive(input int p, input int h, input int n);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < p; c++) begin
                pwm_in = (c < h);
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic hold(input bit lvl, input int n);
        pwm_in = lvl;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(duty_q == 16'd0, "R1 duty", int'(duty_q), 0);
        check(duty_valid == 1'b0, "R1 strobe", int'(duty_valid), 0);
        check(cmd_stale == 1'b0, "R1 stale", int'(cmd_stale), 0);
        @(posedge clk); #1;

        // R2 and R9 forward 25 %
        stale_seen = 0;
        v0 = valid_total;
        drive(100, 25, 6);
        check(last_duty == 8192, "R2 quarter duty", last_duty, 8192);
        check(valid_total - v0 >= 4, "R8 one strobe per period", valid_total - v0, 5);

        // R3 reverse passes through as negative
        dir_rev = 1'b1;
        drive(100, 25, 4);
        check(last_duty == -8192, "R3 reverse duty", last_duty, -8192);
        dir_rev = 1'b0;

        // R9 one-cycle pulses give a small value with no fault
        drive(64, 1, 6);
        check(last_duty == 512, "R9 low duty", last_duty, 512);
        check(stale_seen == 0, "R9 no fault", int'(stale_seen), 0);

        // R2 near full duty
        drive(100, 99, 4);
        check(last_duty == 32440, "R2 high duty", last_duty, 32440);

        // R4 and R6 line held low
        hold(1'b0, 400);
        @(negedge clk);
        check(cmd_stale == 1'b1, "R4 stale after quiet", int'(cmd_stale), 1);
        check(duty_q == 16'd0, "R6 zero duty when stale", int'(duty_q), 0);
        @(posedge clk); #1;

        // R5 first edge clears fault but yields no strobe
        v0 = valid_total;
        drive(50, 20, 1);
        @(negedge clk);
        check(cmd_stale == 1'b0, "R5 cleared by edge", int'(cmd_stale), 0);
        check(valid_total == v0, "R5 no strobe from first edge", valid_total - v0, 0);
        @(posedge clk); #1;
        drive(50, 20, 3);
        check(last_duty == 13107, "R5 duty after recovery", last_duty, 13107);

        // R7 line held high
        hold(1'b1, 400);
        @(negedge clk);
        check(cmd_stale == 1'b1, "R7 stuck high is stale", int'(cmd_stale), 1);
        @(posedge clk); #1;

        // R4 larger limit tolerates a longer gap
        drive(40, 10, 3);
        wdog_limit = WDOG_W'(1000);
        hold(1'b0, 600);
        @(negedge clk);
        check(cmd_stale == 1'b0, "R4 long limit not stale", int'(cmd_stale), 0);
        @(posedge clk); #1;
        hold(1'b0, 500);
        @(negedge clk);
        check(cmd_stale == 1'b1, "R4 long limit expired", int'(cmd_stale), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule